// File: doc/BRIEF.md
# Protected Byte-Store Access Controller

This block gives a CPU access to a small nonvolatile byte array through a few registers on a simple bus: a low and a high address register, a data register, a control register, an unlock register and a completion-flag register. A read is requested through the control register, and its result appears in the data register on the following cycle. The array is modelled as a register array that powers up erased, with every byte at 0xFF.

A write is guarded by three conditions. The write-enable bit must already be set. A two-step unlock key must come just before the request. The memory-region field must select the byte array. Once a write has started, it runs for a fixed number of clock cycles. During that time every access register is frozen. At the end, the new byte replaces the old one, the busy indication drops and a sticky completion flag rises.

Top module: `eeprom_guard`

## Requirements
- R1: After reset, every register reads 0 at offsets 0 (control), 1 (address low), 2 (address high), 3 (data) and 5 (flag), and the flag output is low.
- R2: While idle, values written to offsets 1, 2 and 3 read back unchanged.
- R3: Writing the control register with bit 0 (read request) set and bits 4:3 (region) equal to 00 loads the addressed byte into the data register. The result is readable one cycle after the access, and bit 0 always reads back 0.
- R4: When the region field written with a request is not 00, a read request leaves the data register unchanged and a write request does not start.
- R5: The data register keeps a read value until the next read or until software writes offset 3. Writes to other registers do not change it.
- R6: Setting bit 1 (write request) has no effect if bit 2 (write-enable) was clear before the access. This includes an access that sets both bits.
- R7: A write starts only if the access that requests it comes directly after the bus writes 0x55 and then 0xAA to offset 4. Any other bus write in between breaks the key, and a request consumes the key whether or not it starts a write.
- R8: While a write is busy, bus writes to offsets 0, 1, 2 and 3 are ignored.
- R9: Clearing write-enable while a write is busy neither cancels the write nor changes write-enable.
- R10: Control bit 1 reads 1 for exactly WRITE_CYCLES cycles after the starting access. The stored byte then equals the data register value, replacing the old content with no separate erase step.
- R11: At the end of a write, the flag (offset 5, bit 0, and the flag output) rises and stays set until software writes offset 5 with bit 0 clear. Write-enable keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| irq_flag | output | 1 | Sticky write-complete flag |

## Verification
A register write lands on the clock edge that samples the strobe, so its result is due one cycle after the access. A read request places the byte in the data register at that same edge. The bench drives every access on a falling edge and samples the combinational read path one cycle later, also on a falling edge, so each result is read in the cycle it becomes due. The write period is measured by counting, one per falling edge, the samples in which the busy bit is high, starting from the first edge after the request. The completion flag and the stored byte are checked in the first cycle after busy drops.

// File: rtl/eeprom_guard.sv
module eeprom_guard #(
  parameter int ADDR_W       = 10,
  parameter int WRITE_CYCLES = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] bus_addr,
  input  logic       bus_we,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq_flag
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = $clog2(WRITE_CYCLES + 1);

  logic [7:0]       mem [DEPTH];
  logic [7:0]       adr_lo, adr_hi, data_q;
  logic [1:0]       region, ul;
  logic             wr_en, busy, flag;
  logic [CNT_W-1:0] cnt;

  wire [ADDR_W-1:0] idx = ADDR_W'({adr_hi, adr_lo});
  wire wr_ctrl = bus_we && bus_addr == 3'd0 && !busy;
  wire reg_ok  = bus_wdata[4:3] == 2'b00;
  wire go_rd   = wr_ctrl && bus_wdata[0] && reg_ok;
  wire go_wr   = wr_ctrl && bus_wdata[1] && wr_en && ul == 2'd2 && reg_ok;
  wire done    = busy && cnt == '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ul <= 2'd0;
    end else if (bus_we) begin
      if (bus_addr == 3'd4 && bus_wdata == 8'h55)
        ul <= 2'd1;
      else if (bus_addr == 3'd4 && bus_wdata == 8'hAA && ul == 2'd1)
        ul <= 2'd2;
      else
        ul <= 2'd0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      adr_lo <= '0;
      adr_hi <= '0;
      data_q <= '0;
      region <= '0;
      wr_en  <= 1'b0;
    end else if (bus_we && !busy) begin
      case (bus_addr)
        3'd0: begin
          wr_en  <= bus_wdata[2];
          region <= bus_wdata[4:3];
          if (go_rd) data_q <= mem[idx];
        end
        3'd1: adr_lo <= bus_wdata;
        3'd2: adr_hi <= bus_wdata;
        3'd3: data_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (go_wr) begin
      busy <= 1'b1;
      cnt  <= CNT_W'(WRITE_CYCLES - 1);
    end else if (done) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      flag <= 1'b0;
    else if (done)
      flag <= 1'b1;
    else if (bus_we && bus_addr == 3'd5 && !bus_wdata[0])
      flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (done) begin
      mem[idx] <= data_q;
    end
  end

  always_comb begin
    case (bus_addr)
      3'd0:    bus_rdata = {3'b000, region, wr_en, busy, 1'b0};
      3'd1:    bus_rdata = adr_lo;
      3'd2:    bus_rdata = adr_hi;
      3'd3:    bus_rdata = data_q;
      3'd5:    bus_rdata = {7'd0, flag};
      default: bus_rdata = 8'h00;
    endcase
  end

  assign irq_flag = flag;

  // R6
  wren_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_en));

  // R7
  unlock_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(ul) == 2'd2);

  // R8
  data_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(data_q) && $stable(adr_lo) && $stable(adr_hi));

  // R9
  wren_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(wr_en));

  // R10
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cnt < CNT_W'(WRITE_CYCLES));

  // R11
  flag_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> irq_flag);
endmodule

// File: tb/sim_eeprom_guard.sv
module sim_eeprom_guard;
  localparam int WC = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq_flag;
  int         checks = 0;
  int         fails = 0;
  logic [7:0] v;

  eeprom_guard #(.ADDR_W(10), .WRITE_CYCLES(WC)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_flag(irq_flag));

  always #10 clk = ~clk;

  // {check, offset, value}: check=0 writes value, check=1 compares readback
  localparam logic [11:0] VEC [0:12] = '{
    {1'b0, 3'd1, 8'h12}, {1'b1, 3'd1, 8'h12},   // R2
    {1'b0, 3'd2, 8'h00}, {1'b1, 3'd2, 8'h00},   // R2
    {1'b0, 3'd3, 8'hA5}, {1'b1, 3'd3, 8'hA5},   // R2
    {1'b0, 3'd0, 8'h01}, {1'b1, 3'd3, 8'hFF},   // R3 erased byte read
    {1'b1, 3'd0, 8'h00},                        // R3 request bit reads 0
    {1'b0, 3'd1, 8'h13}, {1'b1, 3'd3, 8'hFF},   // R5
    {1'b0, 3'd3, 8'h5A}, {1'b1, 3'd3, 8'h5A}    // R5
  };

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic key();
    wr(3'd4, 8'h55);
    wr(3'd4, 8'hAA);
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    rd(3'd0, v);
    while (v[1] && n < 5000) begin
      n++;
      @(negedge clk);
      rd(3'd0, v);
    end
  endtask

  initial begin
    #(20 * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 6; a++) begin
      if (a == 4) continue;
      rd(3'(a), v); chk("R1 register reset", v, 8'h00);
    end
    chk("R1 flag output reset", {7'd0, irq_flag}, 8'h00);

    for (int i = 0; i < 13; i++) begin
      if (VEC[i][11]) begin
        rd(VEC[i][10:8], v);
        chk($sformatf("table vector %0d", i), v, VEC[i][7:0]);
      end else begin
        wr(VEC[i][10:8], VEC[i][7:0]);
      end
    end

    wr(3'd1, 8'h05); wr(3'd2, 8'h00); wr(3'd3, 8'h3C);
    wr(3'd0, 8'h00); key(); wr(3'd0, 8'h06);
    rd(3'd0, v); chk("R6 both bits in one access", v, 8'h04);
    rd(3'd3, v); chk("R6 data untouched", v, 8'h3C);

    wr(3'd0, 8'h06);
    rd(3'd0, v); chk("R7 no key", v, 8'h04);
    wr(3'd4, 8'h55); wr(3'd3, 8'h3C); wr(3'd4, 8'hAA); wr(3'd0, 8'h06);
    rd(3'd0, v); chk("R7 broken key", v, 8'h04);
    wr(3'd4, 8'hAA); wr(3'd4, 8'h55); wr(3'd0, 8'h06);
    rd(3'd0, v); chk("R7 reversed key", v, 8'h04);

    key(); wr(3'd0, 8'h0E);
    rd(3'd0, v); chk("R4 other region no write", v, 8'h0C);
    wr(3'd0, 8'h06);
    rd(3'd0, v); chk("R7 key consumed", v, 8'h04);
    wr(3'd0, 8'h11);
    rd(3'd3, v); chk("R4 other region no read", v, 8'h3C);

    wr(3'd0, 8'h04); key(); wr(3'd0, 8'h06);
    wait_idle(n);
    chk("R10 busy length", 8'(n), 8'(WC));
    chk("R11 flag set", {7'd0, irq_flag}, 8'h01);
    rd(3'd0, v); chk("R11 write-enable kept", v, 8'h04);
    wr(3'd0, 8'h05);
    rd(3'd3, v); chk("R10 stored byte", v, 8'h3C);
    rd(3'd5, v); chk("R11 flag sticky", v, 8'h01);
    wr(3'd5, 8'h00);
    rd(3'd5, v); chk("R11 flag cleared", v, 8'h00);

    wr(3'd3, 8'hC3); key(); wr(3'd0, 8'h06);
    wr(3'd1, 8'h40); wr(3'd3, 8'h11); wr(3'd0, 8'h00); wr(3'd2, 8'h02);
    rd(3'd1, v); chk("R8 addr low frozen", v, 8'h05);
    rd(3'd2, v); chk("R8 addr high frozen", v, 8'h00);
    rd(3'd3, v); chk("R8 data frozen", v, 8'hC3);
    rd(3'd0, v); chk("R9 write-enable clear ignored", v, 8'h06);
    wait_idle(n);
    chk("R9 write completed", {7'd0, irq_flag}, 8'h01);
    wr(3'd0, 8'h05);
    rd(3'd3, v); chk("R10 byte replaced not merged", v, 8'hC3);
    wr(3'd1, 8'h40); wr(3'd0, 8'h01);
    rd(3'd3, v); chk("R8 other address untouched", v, 8'hFF);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule